// File: doc/BRIEF.md
# Chip-Wide Power, Soft-Reset and Output-Enable Controller

This block holds the global control settings of a video decoder. The settings sit in three byte-wide registers, which a host writes and reads over a simple single-cycle port. From these registers and two external pins the block does three things. It decides whether the clock of the digital core runs. It drives the power-down lines of four ADCs and a gate on a front-end input that toggles. It works out whether the pixel bus and the sync/field timing outputs drive or float.

There are two sources of power-down: an external pin and a register bit. A priority bit picks which one counts. The register port is never gated, so a host can always wake the core by clearing the bit. A software reset starts when bit 7 of the global register is written as 1. The block then moves from state ST_RUN to state ST_RESET. On that same edge every field with a defined default returns to zero. A two-bit field with no defined default is left as it was. ST_RESET lasts exactly `RST_CYCLES` clocks, and the block then returns to ST_RUN. While in ST_RESET, host writes are refused and reads return zero. The power-down pin and the output-enable pin each pass through two flip-flops before use.

Register map. Address 0 is the global register: bit 7 starts the reset, bit 5 is the power-down bit, bits 4:3 are the kept field, bit 2 is the priority bit and bit 1 is front-end save. Address 1 is the output register: bit 6 is the float bit and bit 5 is the timing-force bit. Address 2 is the ADC register: bit 3 is ADC0, bit 2 is ADC1, bit 1 is ADC2 and bit 0 is ADC3. Address 3 reads as zero.

Top module: `glb_pwr_ctl`

## Requirements
- R1: When the priority bit (address 0, bit 2) is 0, `core_clk_en` is the inverse of the synchronised `pd_pin`, and the power-down bit has no effect.
- R2: When the priority bit is 1, `core_clk_en` is the inverse of the power-down bit (address 0, bit 5), and `pd_pin` has no effect.
- R3: While the core clock is gated, register writes and reads still work. Writing the power-down bit as 0, or a low pulse on `rst_n`, turns `core_clk_en` back to 1.
- R4: `adc_pd[0]`, `adc_pd[1]`, `adc_pd[2]` and `adc_pd[3]` follow bits 3, 2, 1 and 0 of address 2. All four reset to 0.
- R5: `fe_gate` follows address 0 bit 1, which resets to 0.
- R6: Writing address 0 with bit 7 set moves the block from ST_RUN to ST_RESET. `rst_busy` is then high for exactly `RST_CYCLES` cycles. On the starting edge the registers clear to their defaults, and bit 7 reads back as 0.
- R7: The field at address 0 bits 4:3 keeps its value through a software reset. Only `rst_n` clears it.
- R8: A write accepted in ST_RUN pulses `wr_ack` in its own cycle. The write that starts a reset does not raise `wr_ack`.
- R9: In ST_RESET, writes raise `wr_reject`, give no `wr_ack` and change no register. Reads return 8'h00.
- R10: `pix_oe` is 0 when address 1 bit 6 is 1 or when the synchronised `oe_pin` is 1. Otherwise it is 1.
- R11: `tim_oe` equals `pix_oe`, except that it is 1 whenever address 1 bit 5 (timing force) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock, never gated |
| rst_n | input | 1 | Asynchronous active-low full reset pin |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Combinational read data |
| wr_ack | output | 1 | Write accepted this cycle |
| wr_reject | output | 1 | Write refused because a reset is running |
| pd_pin | input | 1 | External power-down request, asynchronous |
| oe_pin | input | 1 | External float request for outputs, asynchronous |
| core_clk_en | output | 1 | Clock-gate enable for the digital core |
| adc_pd | output | 4 | Per-ADC power-down, index = ADC number |
| fe_gate | output | 1 | Blocks the front-end input from internal logic |
| rst_busy | output | 1 | Software reset in progress |
| pix_oe | output | 1 | Pixel bus drive enable |
| tim_oe | output | 1 | Sync/field output drive enable |

## Verification
Some properties are checked on every cycle by the assertions. The reset counter stays inside its window and a start always leads to ST_RESET. No register moves while a refused write is on the port. The power-down and ADC fields stay cleared during ST_RESET. The kept field survives the clearing edge. Acknowledge and reject never appear together. The timing outputs never float while the pixel bus drives. Other behaviour needs the bench's scenarios. One is the exact length of the reset window. Others are the choice between pin and bit for each priority setting, waking through the bit and through the pin, the ADC bit order, and the read-back of the kept field once a reset ends.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] A_GLB = 2'd0;
    localparam logic [ADDR_W-1:0] A_OUT = 2'd1;
    localparam logic [ADDR_W-1:0] A_ADC = 2'd2;

    // bit positions inside the global register
    localparam int B_SRST     = 7;
    localparam int B_PD       = 5;
    localparam int B_KEEP_HI  = 4;
    localparam int B_KEEP_LO  = 3;
    localparam int B_PRIO     = 2;
    localparam int B_FESAVE   = 1;
    // bit positions inside the output register
    localparam int B_FLOAT    = 6;
    localparam int B_TIMFORCE = 5;

    localparam int N_ADC      = 4;

    // mask of bits that survive a software reset (global register, 7 stored bits)
    localparam logic [DATA_W-2:0] KEEP_MASK = 7'b001_1000;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_RESET = 1'b1
    } rst_state_t;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpc_rst_fsm.sv
module gpc_rst_fsm
    import gpc_pkg::*;
#(
    parameter int RST_CYCLES = 54000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    rst_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                cnt_d = '0;
                if (start) state_d = ST_RESET;   // transition: start request
            end
            ST_RESET: begin
                if (cnt_q == LAST) begin         // transition: window elapsed
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:   busy = 1'b0;
            ST_RESET: busy = 1'b1;
        endcase
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST));
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_idle_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cnt_q == '0));
endmodule

// File: rtl/gpc_regs.sv
module gpc_regs
    import gpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              wr_reject,
    output logic              start,
    output logic              pd_bit,
    output logic              prio_bit,
    output logic              fe_save,
    output logic              float_bit,
    output logic              tim_force,
    output logic [N_ADC-1:0]  adc_bits
);
    logic [DATA_W-2:0] glb_q;   // bit 7 is never stored: it self-clears
    logic [DATA_W-1:0] out_q;
    logic [N_ADC-1:0]  adc_q;
    logic              wr_ok;

    assign wr_ok     = wr_en && !busy;
    assign start     = wr_ok && (wr_addr == A_GLB) && wr_data[B_SRST];
    assign wr_ack    = wr_ok && !start;
    assign wr_reject = wr_en && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q <= '0;
            out_q <= '0;
            adc_q <= '0;
        end else if (start) begin
            glb_q <= glb_q & KEEP_MASK;
            out_q <= '0;
            adc_q <= '0;
        end else if (wr_ok) begin
            unique case (wr_addr)
                A_GLB:   glb_q <= wr_data[DATA_W-2:0];
                A_OUT:   out_q <= wr_data;
                A_ADC:   adc_q <= wr_data[N_ADC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (!busy) begin
            unique case (rd_addr)
                A_GLB:   rd_data = {1'b0, glb_q};
                A_OUT:   rd_data = out_q;
                A_ADC:   rd_data = {{(DATA_W-N_ADC){1'b0}}, adc_q};
                default: rd_data = '0;
            endcase
        end
    end

    assign pd_bit    = glb_q[B_PD];
    assign prio_bit  = glb_q[B_PRIO];
    assign fe_save   = glb_q[B_FESAVE];
    assign float_bit = out_q[B_FLOAT];
    assign tim_force = out_q[B_TIMFORCE];
    assign adc_bits  = adc_q;

    p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(glb_q) && $stable(out_q) && $stable(adc_q)));
    p_selfclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!glb_q[B_PD] && adc_q == '0 && out_q == '0));
    p_keep_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (glb_q[B_KEEP_HI:B_KEEP_LO] == $past(glb_q[B_KEEP_HI:B_KEEP_LO])));
    p_ack_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ack && wr_reject));
endmodule

// File: rtl/glb_pwr_ctl.sv
module glb_pwr_ctl
    import gpc_pkg::*;
#(
    parameter int RST_CYCLES = 54000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              wr_reject,
    input  logic              pd_pin,
    input  logic              oe_pin,
    output logic              core_clk_en,
    output logic [N_ADC-1:0]  adc_pd,
    output logic              fe_gate,
    output logic              rst_busy,
    output logic              pix_oe,
    output logic              tim_oe
);
    logic             busy, start;
    logic             pd_bit, prio_bit, fe_save, float_bit, tim_force;
    logic [N_ADC-1:0] adc_bits;
    logic [1:0]       pins_s;
    logic             pd_sel, float_cond;

    gpc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({oe_pin, pd_pin}),
        .q     (pins_s)
    );

    gpc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_ack    (wr_ack),
        .wr_reject (wr_reject),
        .start     (start),
        .pd_bit    (pd_bit),
        .prio_bit  (prio_bit),
        .fe_save   (fe_save),
        .float_bit (float_bit),
        .tim_force (tim_force),
        .adc_bits  (adc_bits)
    );

    gpc_rst_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    // power-down source selection, registered so the gate moves on an edge
    assign pd_sel = prio_bit ? pd_bit : pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_clk_en <= 1'b1;
        else        core_clk_en <= !pd_sel;
    end

    // ADC index i maps to register bit N_ADC-1-i
    genvar i;
    generate
        for (i = 0; i < N_ADC; i++) begin : g_adc
            assign adc_pd[i] = adc_bits[N_ADC-1-i];
        end
    endgenerate

    assign fe_gate    = fe_save;
    assign rst_busy   = busy;
    assign float_cond = float_bit || pins_s[1];
    assign pix_oe     = !float_cond;
    assign tim_oe     = !float_cond || tim_force;

    p_tim_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_oe |-> !pix_oe);
    p_busy_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> (adc_pd == '0 && !fe_gate));
endmodule

// File: tb/glb_pwr_ctl_bench.sv
module glb_pwr_ctl_bench;
    localparam int RST_N_CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic       pd_pin = 1'b0;
    logic       oe_pin = 1'b0;
    logic [7:0] rd_data;
    logic       wr_ack, wr_reject, core_clk_en, fe_gate, rst_busy, pix_oe, tim_oe;
    logic [3:0] adc_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard queues
    int         q_id [$];
    logic [7:0] q_exp [$];
    string      q_req [$];

    glb_pwr_ctl #(.RST_CYCLES(RST_N_CYC)) u_glb_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_ack(wr_ack), .wr_reject(wr_reject), .pd_pin(pd_pin),
        .oe_pin(oe_pin), .core_clk_en(core_clk_en), .adc_pd(adc_pd),
        .fe_gate(fe_gate), .rst_busy(rst_busy), .pix_oe(pix_oe),
        .tim_oe(tim_oe)
    );

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [7:0] actual(int id);
        case (id)
            0: return {7'd0, core_clk_en};
            1: return {4'd0, adc_pd};
            2: return {7'd0, fe_gate};
            3: return {7'd0, rst_busy};
            4: return {7'd0, wr_reject};
            5: return {7'd0, pix_oe};
            6: return {7'd0, tim_oe};
            7: return rd_data;
            default: return {7'd0, wr_ack};
        endcase
    endfunction

    // monitor: pops expectations away from the active edge
    always @(negedge clk) begin
        while (q_id.size() > 0) begin
            int id;
            logic [7:0] ex, ac;
            string rq;
            id = q_id.pop_front();
            ex = q_exp.pop_front();
            rq = q_req.pop_front();
            ac = actual(id);
            checks++;
            if (ac !== ex) begin
                errors++;
                $display("FAIL %s: signal %0d actual %h expected %h", rq, id, ac, ex);
            end
        end
    end

    task automatic expect_item(input int id, input logic [7:0] ex, input string rq);
        q_id.push_back(id);
        q_exp.push_back(ex);
        q_req.push_back(rq);
    endtask

    task automatic direct(input int ac, input int ex, input string rq);
        checks++;
        if (ac != ex) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, ac, ex);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d,
                      input logic ack, input logic rej, input string rq);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        expect_item(8, {7'd0, ack}, rq);
        expect_item(4, {7'd0, rej}, rq);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] ex, input string rq);
        @(posedge clk); #1;
        rd_addr = a;
        expect_item(7, ex, rq);
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int n;
        settle(3);
        rst_n = 1'b1;
        settle(2);
        // reset state
        expect_item(0, 8'h01, "R3 reset clk_en");
        expect_item(1, 8'h00, "R4 reset adc");
        expect_item(2, 8'h00, "R5 reset fe");
        expect_item(3, 8'h00, "R6 reset busy");
        expect_item(5, 8'h01, "R10 reset pix");
        expect_item(6, 8'h01, "R11 reset tim");
        rd(2'd0, 8'h00, "R6 reset glb");

        // R1: pin governs, bit ignored
        pd_pin = 1'b1; settle(4);
        expect_item(0, 8'h00, "R1 pin down");
        wr(2'd0, 8'h20, 1'b1, 1'b0, "R8 ack pd bit");
        pd_pin = 1'b0; settle(4);
        expect_item(0, 8'h01, "R1 bit ignored");

        // R2: bit governs, pin ignored
        wr(2'd0, 8'h24, 1'b1, 1'b0, "R2 select bit");
        settle(2);
        expect_item(0, 8'h00, "R2 bit down");
        pd_pin = 1'b1; settle(4); pd_pin = 1'b0; settle(4);
        expect_item(0, 8'h00, "R2 pin ignored");
        // R3: interface alive and wake by bit
        rd(2'd0, 8'h24, "R3 read while gated");
        wr(2'd0, 8'h04, 1'b1, 1'b0, "R3 write while gated");
        settle(2);
        expect_item(0, 8'h01, "R3 wake by bit");
        // R3: wake by reset pin
        wr(2'd0, 8'h24, 1'b1, 1'b0, "R3 re-gate");
        settle(2);
        expect_item(0, 8'h00, "R3 gated again");
        settle(1);
        rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(2);
        expect_item(0, 8'h01, "R3 wake by pin reset");
        rd(2'd0, 8'h00, "R3 regs cleared by pin");

        // R4: ADC order
        wr(2'd2, 8'h08, 1'b1, 1'b0, "R4 write");
        expect_item(1, 8'h01, "R4 bit3 to adc0");
        wr(2'd2, 8'h01, 1'b1, 1'b0, "R4 write");
        expect_item(1, 8'h08, "R4 bit0 to adc3");
        wr(2'd2, 8'h06, 1'b1, 1'b0, "R4 write");
        expect_item(1, 8'h06, "R4 middle bits");
        rd(2'd2, 8'h06, "R4 readback");

        // R5: front-end gate
        wr(2'd0, 8'h02, 1'b1, 1'b0, "R5 write");
        expect_item(2, 8'h01, "R5 gate on");
        wr(2'd0, 8'h00, 1'b1, 1'b0, "R5 write");
        expect_item(2, 8'h00, "R5 gate off");

        // R10 / R11: output enables
        wr(2'd1, 8'h40, 1'b1, 1'b0, "R10 float bit");
        expect_item(5, 8'h00, "R10 pix float by bit");
        expect_item(6, 8'h00, "R11 tim float by bit");
        wr(2'd1, 8'h00, 1'b1, 1'b0, "R10 clear");
        oe_pin = 1'b1; settle(4);
        expect_item(5, 8'h00, "R10 pix float by pin");
        wr(2'd1, 8'h20, 1'b1, 1'b0, "R11 force");
        expect_item(5, 8'h00, "R11 pix still float");
        expect_item(6, 8'h01, "R11 tim forced");
        oe_pin = 1'b0; settle(4);
        wr(2'd1, 8'h00, 1'b1, 1'b0, "R10 clear");
        expect_item(5, 8'h01, "R10 pix drives");

        // R6 / R7: software reset length, clearing, kept field
        wr(2'd0, 8'h1A, 1'b1, 1'b0, "R7 preload");
        wr(2'd1, 8'h40, 1'b1, 1'b0, "R6 preload");
        wr(2'd2, 8'h0F, 1'b1, 1'b0, "R6 preload");
        wr(2'd0, 8'h9A, 1'b0, 1'b0, "R8 start not acked");
        n = 0;
        forever begin
            @(negedge clk);
            if (rst_busy) n++;
            else break;
        end
        direct(n, RST_N_CYC, "R6 busy length");
        settle(1);
        rd(2'd0, 8'h18, "R7 kept field, R6 others cleared");
        rd(2'd1, 8'h00, "R6 out reg cleared");
        rd(2'd2, 8'h00, "R6 adc reg cleared");
        expect_item(1, 8'h00, "R6 adc lines cleared");
        expect_item(5, 8'h01, "R6 pix enabled");

        // R9: refused writes and zero reads during reset
        wr(2'd0, 8'h80, 1'b0, 1'b0, "R8 start not acked");
        expect_item(3, 8'h01, "R9 busy");
        wr(2'd2, 8'h05, 1'b0, 1'b1, "R9 write rejected");
        rd(2'd0, 8'h00, "R9 read zero");
        while (rst_busy) settle(1);
        settle(1);
        rd(2'd2, 8'h00, "R9 write had no effect");
        expect_item(1, 8'h00, "R9 adc unchanged");
        rd(2'd0, 8'h18, "R7 kept over second reset");

        settle(2);
        finish_run();
    end
endmodule